// File: doc/BRIEF.md
# Packed halfword shift-add unit

This execution unit handles two packed-SIMD operations on 64-bit register values. It treats each operand as four signed 16-bit lanes. In every lane it scales the first operand by a shift of 0 to 3 places, either left or arithmetic right, adds the matching lane of the second operand, and clamps the sum to the signed 16-bit range. The sum is formed at a width where no bits can be lost, so the clamp always sees the true value.

The unit receives a 32-bit instruction word, the two operand values already read from the register file, and a flag that is high in 64-bit architecture mode. It decodes the word and reports whether it claims it. When it claims the word it also gives the direction, the destination register index and the lane result. The source register indices are extracted for the register-file read ports.

An encoding with a zero shift amount belongs to the carry and borrow arithmetic operations, so the unit must not claim it. A registered copy of the claim flag, the result and the destination index is loaded when a load strobe is high.

Top module: `hsadd_unit`

## Requirements
- R1: The word is claimed as a left-shift operation (hit=1, is_left=1, is_right=0) when bits [31:26]=000010, [15:12]=0000, [11:8]=0111, [7:6]≠00, bit [5]=0 and wide_mode=1.
- R2: The word is claimed as a right-shift operation (hit=1, is_right=1, is_left=0) under the same conditions as R1, except that bits [11:8]=0101.
- R3: A word with shift field [7:6]=00 is never claimed, whatever its other bits are.
- R4: When wide_mode=0 no word is claimed.
- R5: Any other value in [31:26], a nonzero [15:12], bit [5]=1, or any other value in [11:8] gives no claim. Whenever hit=0, result is all zeros and is_left and is_right are both 0.
- R6: For a left-shift claim, lane i (bits [16i+15:16i]) of result is clamp(shift_val lane i × 2^sh + add_val lane i), where both lanes are signed.
- R7: For a right-shift claim, lane i of result is clamp(floor(shift_val lane i / 2^sh) + add_val lane i), where the right shift is arithmetic and keeps the sign.
- R8: clamp maps values above 32767 to 32767 and values below -32768 to -32768. No lane wraps, including in the extreme cases -32768·8-32768 and 32767·8+32767.
- R9: dest_idx equals bits [4:0], shift_idx equals bits [20:16] and add_idx equals bits [25:21], whether or not the word is claimed.
- R10: On a rising clock edge with load=1 and rst=0, r_hit, r_result and r_dest take the values of hit, result and dest_idx. With load=0 they hold their values.
- R11: On a rising clock edge with rst=1, r_hit, r_result and r_dest clear to zero. Reset has priority over load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Loads the output register |
| insn | input | 32 | Instruction word |
| wide_mode | input | 1 | High in 64-bit architecture mode |
| shift_val | input | 64 | Value of the register that is shifted |
| add_val | input | 64 | Value of the register that is added |
| result | output | 64 | Combinational lane result, zero when not claimed |
| hit | output | 1 | Word claimed by this unit |
| is_left | output | 1 | Claimed as the left-shift operation |
| is_right | output | 1 | Claimed as the right-shift operation |
| dest_idx | output | 5 | Destination register index |
| shift_idx | output | 5 | Index of the shifted source register |
| add_idx | output | 5 | Index of the added source register |
| r_result | output | 64 | Registered result |
| r_hit | output | 1 | Registered claim flag |
| r_dest | output | 5 | Registered destination index |

## Verification
Random operand lanes at small shift amounts exercise the plain add path. Lanes held near ±32768 with a shift of 3 make the clamp fire from both sides, and this separates a correct wide intermediate from one that wraps. Negative odd lanes under a right shift separate an arithmetic shift from a logical one, and rounding toward minus infinity from rounding toward zero. Words that differ from a legal encoding in a single field (shift 00, mode clear, a reserved bit set, a neighbouring sub-opcode) show that the decoder gives way exactly where it should.

// File: rtl/hsadd_unit.sv
module hsadd_unit #(
  parameter int LANES = 4,
  parameter int LW    = 16,
  parameter int SHW   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [31:0]         insn,
  input  logic                wide_mode,
  input  logic [LANES*LW-1:0] shift_val,
  input  logic [LANES*LW-1:0] add_val,
  output logic [LANES*LW-1:0] result,
  output logic                hit,
  output logic                is_left,
  output logic                is_right,
  output logic [4:0]          dest_idx,
  output logic [4:0]          shift_idx,
  output logic [4:0]          add_idx,
  output logic [LANES*LW-1:0] r_result,
  output logic                r_hit,
  output logic [4:0]          r_dest
);
  localparam int DW = LANES * LW;
  localparam int EW = LW + (1 << SHW) + 1;
  localparam logic signed [EW-1:0] MAXV = EW'((1 << (LW - 1)) - 1);
  localparam logic signed [EW-1:0] MINV = EW'(-(1 << (LW - 1)));

  logic [SHW-1:0] sh;
  logic           form_ok, want_left, want_right, claim;
  logic [DW-1:0]  lanes;

  assign sh         = insn[7:6];
  assign form_ok    = (insn[31:26] == 6'b000010) && (insn[15:12] == 4'b0000) && !insn[5];
  assign want_left  = (insn[11:8] == 4'b0111);
  assign want_right = (insn[11:8] == 4'b0101);
  assign claim      = form_ok && (sh != '0) && wide_mode;

  assign is_left   = claim && want_left;
  assign is_right  = claim && want_right;
  assign hit       = is_left || is_right;
  assign dest_idx  = insn[4:0];
  assign shift_idx = insn[20:16];
  assign add_idx   = insn[25:21];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [EW-1:0] sa, sb, sc, sum;
    assign sa  = EW'(signed'(shift_val[g*LW +: LW]));
    assign sb  = EW'(signed'(add_val[g*LW +: LW]));
    assign sc  = want_left ? (sa <<< sh) : (sa >>> sh);
    assign sum = sc + sb;
    assign lanes[g*LW +: LW] = (sum > MAXV) ? MAXV[LW-1:0] :
                               (sum < MINV) ? MINV[LW-1:0] : sum[LW-1:0];
  end

  assign result = hit ? lanes : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_hit    <= 1'b0;
      r_result <= '0;
      r_dest   <= '0;
    end else if (load) begin
      r_hit    <= hit;
      r_result <= result;
      r_dest   <= dest_idx;
    end
  end

  // R3
  sh_zero_yield_chk: assert property (@(posedge clk) disable iff (rst)
    (insn[7:6] == 2'b00) |-> !hit);
  // R4
  mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !wide_mode |-> !hit);
  // R5
  dir_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_left, is_right}));
  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (result == '0));
  // R10
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (r_result == $past(result)) && (r_hit == $past(hit)));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(r_result) && $stable(r_hit) && $stable(r_dest));
endmodule

// File: tb/hsadd_unit_tb.sv
`timescale 1ns/1ps
module hsadd_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [31:0] insn = '0;
  logic        wide_mode = 1'b1;
  logic [63:0] shift_val = '0, add_val = '0;
  logic [63:0] result, r_result;
  logic        hit, is_left, is_right, r_hit;
  logic [4:0]  dest_idx, shift_idx, add_idx, r_dest;

  int total = 0, fails = 0;
  bit done = 0;
  logic [63:0] m_result = '0;
  logic        m_hit = 1'b0;
  logic [4:0]  m_dest = '0;

  always #2.5 clk = ~clk;

  hsadd_unit u_dut (
    .clk(clk), .rst(rst), .load(load), .insn(insn), .wide_mode(wide_mode),
    .shift_val(shift_val), .add_val(add_val), .result(result), .hit(hit),
    .is_left(is_left), .is_right(is_right), .dest_idx(dest_idx),
    .shift_idx(shift_idx), .add_idx(add_idx), .r_result(r_result),
    .r_hit(r_hit), .r_dest(r_dest));

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] ra, logic [4:0] rs,
                                     logic [3:0] z, logic [3:0] sub, logic [1:0] s,
                                     logic b5, logic [4:0] t);
    return {op, ra, rs, z, sub, s, b5, t};
  endfunction

  function automatic bit ref_left(logic [31:0] w, logic m);
    return m && w[31:26] == 6'b000010 && w[15:12] == 0 && !w[5] && w[7:6] != 0 && w[11:8] == 4'b0111;
  endfunction

  function automatic bit ref_right(logic [31:0] w, logic m);
    return m && w[31:26] == 6'b000010 && w[15:12] == 0 && !w[5] && w[7:6] != 0 && w[11:8] == 4'b0101;
  endfunction

  function automatic logic [63:0] ref_res(logic [31:0] w, logic m, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    bit l = ref_left(w, m);
    bit rr = ref_right(w, m);
    int s = int'(w[7:6]);
    if (!l && !rr) return '0;
    for (int i = 0; i < 4; i++) begin
      int f1 = int'(signed'(a[16*i +: 16]));
      int f2 = int'(signed'(b[16*i +: 16]));
      int fr = l ? (f1 * (1 << s)) : (f1 >>> s);
      fr = fr + f2;
      if (fr > 32767) fr = 32767;
      if (fr < -32768) fr = -32768;
      r[16*i +: 16] = fr[15:0];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, logic m, logic [63:0] a, logic [63:0] b,
                       logic ld, string tag);
    logic [63:0] e;
    @(negedge clk);
    insn = w; wide_mode = m; shift_val = a; add_val = b; load = ld;
    #1;
    e = ref_res(w, m, a, b);
    chk({tag, " result"}, result, e);
    chk({tag, " flags"}, {61'd0, hit, is_left, is_right},
        {61'd0, ref_left(w, m) | ref_right(w, m), ref_left(w, m), ref_right(w, m)});
    chk("R9 indices", {49'd0, dest_idx, shift_idx, add_idx}, {49'd0, w[4:0], w[20:16], w[25:21]});
    if (ld && !rst) begin
      m_result = e; m_hit = ref_left(w, m) | ref_right(w, m); m_dest = w[4:0];
    end
    @(posedge clk); #1;
    chk("R10 registered", {r_result}, m_result);
    chk("R10 registered flag/dest", {58'd0, r_hit, r_dest}, {58'd0, m_hit, m_dest});
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset state", r_result, '0);
    chk("R11 reset flag", {63'd0, r_hit}, 64'd0);
    @(negedge clk); rst = 1'b0;

    apply(mk(6'h02, 5'd3, 5'd4, 4'h0, 4'b0111, 2'd1, 1'b0, 5'd9), 1, 64'h0001_0002_FFFF_0010,
          64'h0005_0005_0005_0005, 1, "R1 R6 left sh1");
    apply(mk(6'h02, 5'd7, 5'd8, 4'h0, 4'b0111, 2'd3, 1'b0, 5'd31), 1, 64'h8000_7FFF_8000_7FFF,
          64'h8000_7FFF_7FFF_8000, 1, "R8 left extremes");
    apply(mk(6'h02, 5'd1, 5'd2, 4'h0, 4'b0101, 2'd1, 1'b0, 5'd5), 1, 64'hFFFD_0003_FFFF_0007,
          64'h0000_0000_0000_0000, 1, "R2 R7 right odd");
    apply(mk(6'h02, 5'd1, 5'd2, 4'h0, 4'b0101, 2'd3, 1'b0, 5'd6), 1, 64'h8000_7FFF_8000_0008,
          64'h8000_7FFF_7FFF_FFFF, 1, "R8 right extremes");
    apply(mk(6'h02, 5'd1, 5'd2, 4'h0, 4'b0111, 2'd0, 1'b0, 5'd6), 1, 64'h1234_5678_9ABC_DEF0,
          64'h1111_2222_3333_4444, 1, "R3 left sh0");
    apply(mk(6'h02, 5'd1, 5'd2, 4'h0, 4'b0101, 2'd0, 1'b0, 5'd6), 1, 64'h1234_5678_9ABC_DEF0,
          64'h1111_2222_3333_4444, 1, "R3 right sh0");
    apply(mk(6'h02, 5'd1, 5'd2, 4'h0, 4'b0111, 2'd2, 1'b0, 5'd6), 0, 64'h0001_0001_0001_0001,
          64'h0001_0001_0001_0001, 1, "R4 mode clear");
    apply(mk(6'h02, 5'd1, 5'd2, 4'h8, 4'b0111, 2'd2, 1'b0, 5'd6), 1, 64'h0001_0001_0001_0001,
          64'h0001_0001_0001_0001, 1, "R5 reserved high");
    apply(mk(6'h02, 5'd1, 5'd2, 4'h0, 4'b0111, 2'd2, 1'b1, 5'd6), 1, 64'h0001_0001_0001_0001,
          64'h0001_0001_0001_0001, 1, "R5 bit5 set");
    apply(mk(6'h03, 5'd1, 5'd2, 4'h0, 4'b0111, 2'd2, 1'b0, 5'd6), 1, 64'h0001_0001_0001_0001,
          64'h0001_0001_0001_0001, 1, "R5 major opcode");
    apply(mk(6'h02, 5'd1, 5'd2, 4'h0, 4'b0110, 2'd2, 1'b0, 5'd6), 1, 64'h0001_0001_0001_0001,
          64'h0001_0001_0001_0001, 1, "R5 sub-opcode");
    apply(mk(6'h02, 5'd1, 5'd2, 4'h0, 4'b0111, 2'd1, 1'b0, 5'd12), 1, 64'h0100_0100_0100_0100,
          64'h0, 1, "R10 load");
    apply(mk(6'h02, 5'd1, 5'd2, 4'h0, 4'b0101, 2'd2, 1'b0, 5'd17), 1, 64'h7000_7000_7000_7000,
          64'h1, 0, "R10 hold");

    @(negedge clk);
    rst = 1'b1; load = 1'b1;
    insn = mk(6'h02, 5'd1, 5'd2, 4'h0, 4'b0111, 2'd1, 1'b0, 5'd3);
    @(posedge clk); #1;
    chk("R11 reset over load", r_result, '0);
    chk("R11 reset over load flag", {58'd0, r_hit, r_dest}, 64'd0);
    m_result = '0; m_hit = 0; m_dest = '0;
    @(negedge clk); rst = 1'b0; load = 1'b0;

    void'($urandom(32'd1234));
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      logic [63:0] a, b;
      logic m;
      int pick = $urandom_range(0, 9);
      w = mk(6'h02, 5'($urandom), 5'($urandom), 4'h0,
             ($urandom_range(0, 1) != 0) ? 4'b0111 : 4'b0101, 2'($urandom), 1'b0, 5'($urandom));
      if (pick == 0) w[15:12] = 4'($urandom);
      if (pick == 1) w[5] = 1'b1;
      if (pick == 2) w[11:8] = 4'($urandom);
      m = (pick == 3) ? 1'b0 : 1'b1;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (pick >= 8) begin
        a = {4{(($urandom_range(0, 1) != 0) ? 16'h8000 : 16'h7FFF)}};
        b = {4{16'($urandom_range(0, 1) != 0 ? 16'h8001 : 16'h7FFE)}};
      end
      apply(w, m, a, b, 1'($urandom), w[9] ? "R6 random" : "R7 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule